// File: doc/BRIEF.md
# SCSI Expansion Slot Host Glue

This block sits between a host bus and a SCSI bus controller on a 64 KB expansion slot. The host makes single byte or word accesses with a one-cycle strobe. Read data comes back combinationally in the same cycle. Writes take effect at the clock edge that ends the strobe.

Address bit 15 splits the slot into two halves:
- The lower half is a boot ROM. The ROM lives outside this block and is reached through two byte-address ports, so a word read can fetch an adjacent byte pair.
- The upper half holds a board status/control byte, a data port, and a direct window onto the controller's pointer and register.

The data port always reaches the controller's data register. The controller's register pointer is left as it was. The block also does three more things:
- It snoops pointer writes, so it knows when the direct window hits the data register.
- It raises a programmed-I/O interrupt when data is waiting and the interrupt is enabled.
- It holds the controller in reset while one status bit is clear.

Top module: `scsi_slot_glue`

## Requirements
- R1: With address bit 15 clear, a byte read returns the ROM byte at that address in bits 7:0, with bits 15:8 zero. A word read returns the byte at the address in bits 15:8 and the byte at address+1 in bits 7:0.
- R2: ROM bytes at or above ROM_BYTES (including address+1 = 0x8000) read as 0xFF. Writes with address bit 15 clear change nothing.
- R3: With bit 15 set, a byte read where (addr & 0xF1) == 0x80 returns the stored status bits 6:0, with bit 7 taken from the controller's data-available input.
- R4: A byte write where (addr & 0xF0) == 0x80 stores host_wdata[6:0] as the status bits. Bit 4 enables the interrupt. Bit 3 is the interrupt-pending flag. Bit 6 is the controller run bit.
- R5: ctl_reset is high exactly while status bit 6 is 0. Reset clears the status to 0x00, so ctl_reset is high and irq is low after reset. While ctl_reset is high, the pointer shadow reads as zero.
- R6: The data port is reached by a byte read where (addr & 0xF1) == 0x81, or a byte write where (addr & 0xF1) == 0xE1. It accesses the controller data register (ctl_port = 2) and leaves the controller's pointer unchanged.
- R7: A byte access to 0xC1 uses ctl_port = 0: a read returns auxiliary status and a write loads the pointer. A byte access to 0xC3 uses ctl_port = 1 and reaches the register the pointer selects.
- R8: A data-register access counts as an interrupt event when ctl_data_avail is high and status bit 4 is set; status bit 3 is then set at that clock edge. Data-register accesses are data-port accesses, word reads in the 0x80 range, and 0xC3 accesses while the pointer equals DATA_REG (0x19). irq equals status bit 3.
- R9: irq stays high until a status write clears bit 3, or until reset.
- R10: A word read where (addr & 0xF0) == 0x80 returns the status byte (as in R3) in bits 15:8 and a data-register read in bits 7:0. Word writes to the register half have no effect.
- R11: Register-half reads at any other offset return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = word access, 0 = byte access |
| host_addr | input | 16 | Byte address within the slot |
| host_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| host_rdata | output | 16 | Read data, valid in the strobe cycle |
| irq | output | 1 | Programmed-I/O data interrupt |
| rom_addr0 | output | 15 | ROM byte address |
| rom_addr1 | output | 15 | ROM byte address + 1 |
| rom_byte0 | input | 8 | ROM byte at rom_addr0 |
| rom_byte1 | input | 8 | ROM byte at rom_addr1 |
| ctl_sel | output | 1 | Controller access strobe |
| ctl_we | output | 1 | Controller write |
| ctl_port | output | 2 | 0 = aux/pointer, 1 = selected register, 2 = data register |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data |
| ctl_data_avail | input | 1 | Controller has data ready |
| ctl_reset | output | 1 | Controller reset |

## Verification
Read data is combinational, so each read is compared 8 ns into the strobe cycle, before the closing edge. Status, pointer shadow, irq and ctl_reset change at the edge that ends the strobe. They are compared 2 ns after that edge, once per access. The bench model applies each access's effect at that same edge. It uses the pre-edge status, pointer and data-available values to decide whether an interrupt event occurred.

// File: rtl/scsi_slot_glue.sv
module scsi_slot_glue #(
  parameter int          ROM_BYTES = 16384,
  parameter logic [7:0]  DATA_REG  = 8'h19
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_req,
  input  logic        host_we,
  input  logic        host_word,
  input  logic [15:0] host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        irq,
  output logic [14:0] rom_addr0,
  output logic [14:0] rom_addr1,
  input  logic [7:0]  rom_byte0,
  input  logic [7:0]  rom_byte1,
  output logic        ctl_sel,
  output logic        ctl_we,
  output logic [1:0]  ctl_port,
  output logic [7:0]  ctl_wdata,
  input  logic [7:0]  ctl_rdata,
  input  logic        ctl_data_avail,
  output logic        ctl_reset
);
  localparam logic [1:0] PORT_AUX  = 2'd0;
  localparam logic [1:0] PORT_IND  = 2'd1;
  localparam logic [1:0] PORT_DATA = 2'd2;
  localparam logic [15:0] ROM_LIMIT = 16'(ROM_BYTES);

  logic [6:0] st_q;
  logic [7:0] ptr_q;

  wire [7:0]  lo      = host_addr[7:0];
  wire        reg_hit = host_req & host_addr[15];
  wire        rd_b    = ~host_we & ~host_word;
  wire        wr_b    = host_we & ~host_word;

  wire st_rd  = rd_b & ((lo & 8'hF1) == 8'h80);
  wire dp_rd  = rd_b & ((lo & 8'hF1) == 8'h81);
  wire wst_rd = ~host_we & host_word & ((lo & 8'hF0) == 8'h80);
  wire st_wr  = reg_hit & wr_b & ((lo & 8'hF0) == 8'h80);
  wire dp_wr  = wr_b & ((lo & 8'hF1) == 8'hE1);
  wire aux_a  = ~host_word & (lo == 8'hC1);
  wire ind_a  = ~host_word & (lo == 8'hC3);

  wire data_acc = reg_hit & (dp_rd | dp_wr | wst_rd | (ind_a & (ptr_q == DATA_REG)));
  wire [7:0] st_byte = {ctl_data_avail, st_q};

  assign ctl_sel   = reg_hit & (dp_rd | dp_wr | wst_rd | aux_a | ind_a);
  assign ctl_we    = host_we;
  assign ctl_port  = aux_a ? PORT_AUX : ind_a ? PORT_IND : PORT_DATA;
  assign ctl_wdata = host_wdata[7:0];
  assign ctl_reset = ~st_q[6];
  assign irq       = st_q[3];

  wire [15:0] a0 = {1'b0, host_addr[14:0]};
  wire [15:0] a1 = a0 + 16'd1;
  assign rom_addr0 = a0[14:0];
  assign rom_addr1 = a1[14:0];
  wire [7:0] rb0 = (a0 < ROM_LIMIT) ? rom_byte0 : 8'hFF;
  wire [7:0] rb1 = (a1 < ROM_LIMIT) ? rom_byte1 : 8'hFF;

  always_comb begin
    host_rdata = 16'h0000;
    if (!host_addr[15])
      host_rdata = host_word ? {rb0, rb1} : {8'h00, rb0};
    else if (wst_rd)
      host_rdata = {st_byte, ctl_rdata};
    else if (st_rd)
      host_rdata = {8'h00, st_byte};
    else if (!host_we && (dp_rd || aux_a || ind_a))
      host_rdata = {8'h00, ctl_rdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= 7'h00;
      ptr_q <= 8'h00;
    end else begin
      if (st_wr)
        st_q <= host_wdata[6:0];
      else if (data_acc && ctl_data_avail && st_q[4])
        st_q[3] <= 1'b1;
      if (ctl_reset)
        ptr_q <= 8'h00;
      else if (reg_hit && wr_b && aux_a)
        ptr_q <= host_wdata[7:0];
    end
  end

  AST_ROM_NO_CTL: assert property (@(posedge clk) disable iff (rst)
    host_req && !host_addr[15] |-> !ctl_sel);                          // R2
  AST_WORD_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    host_req && host_we && host_word |=> $stable(st_q));               // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    irq && !st_wr |=> irq);                                            // R9
  AST_RESET_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    st_wr && !host_wdata[6] |=> ctl_reset);                            // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(st_wr) || $past(data_acc && ctl_data_avail)); // R8
  AST_PTR_KEPT: assert property (@(posedge clk) disable iff (rst)
    ctl_sel && ctl_port == PORT_DATA && !ctl_reset |=> $stable(ptr_q)); // R6
endmodule

// File: tb/scsi_slot_glue_bench.sv
module scsi_slot_glue_bench;
  localparam int ROM_BYTES = 16384;
  localparam logic [7:0] DATA_REG = 8'h19;

  logic clk = 0, rst = 1;
  logic host_req = 0, host_we = 0, host_word = 0;
  logic [15:0] host_addr = 0, host_wdata = 0;
  logic [15:0] host_rdata;
  logic irq, ctl_sel, ctl_we, ctl_reset;
  logic [14:0] rom_addr0, rom_addr1;
  logic [7:0] rom_byte0, rom_byte1, ctl_wdata, ctl_rdata;
  logic [1:0] ctl_port;
  logic dav = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_regs [32];
  logic [7:0] m_ptr = 0;
  logic [6:0] e_st = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] romf(input logic [14:0] a);
    return 8'(a * 7 + 3) ^ a[14:7];
  endfunction

  assign rom_byte0 = romf(rom_addr0);
  assign rom_byte1 = romf(rom_addr1);
  wire [7:0] aux_val = {dav, 2'b00, 5'h01};
  assign ctl_rdata = ctl_port == 2'd0 ? aux_val :
                     ctl_port == 2'd1 ? m_regs[m_ptr[4:0]] : m_regs[DATA_REG[4:0]];

  scsi_slot_glue #(.ROM_BYTES(ROM_BYTES), .DATA_REG(DATA_REG)) u_scsi_slot_glue (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_word(host_word),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .rom_addr0(rom_addr0), .rom_addr1(rom_addr1), .rom_byte0(rom_byte0), .rom_byte1(rom_byte1),
    .ctl_sel(ctl_sel), .ctl_we(ctl_we), .ctl_port(ctl_port), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ctl_data_avail(dav), .ctl_reset(ctl_reset));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input logic [15:0] a);
    return (a < 16'(ROM_BYTES)) ? romf(a[14:0]) : 8'hFF;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [15:0] a, input logic word);
    logic [7:0] lo = a[7:0];
    logic [15:0] a0 = {1'b0, a[14:0]};
    logic [7:0] stb = {dav, e_st};
    if (!a[15]) return word ? {rb(a0), rb(a0 + 16'd1)} : {8'h00, rb(a0)};
    if (word) return ((lo & 8'hF0) == 8'h80) ? {stb, m_regs[DATA_REG[4:0]]} : 16'h0;
    if ((lo & 8'hF1) == 8'h80) return {8'h00, stb};
    if ((lo & 8'hF1) == 8'h81) return {8'h00, m_regs[DATA_REG[4:0]]};
    if (lo == 8'hC1) return {8'h00, aux_val};
    if (lo == 8'hC3) return {8'h00, m_regs[m_ptr[4:0]]};
    return 16'h0;
  endfunction

  task automatic op(input logic we, input logic word, input logic [15:0] a,
                    input logic [15:0] wd, input string req);
    logic [7:0] lo = a[7:0];
    logic hi = a[15];
    logic in_rst = ~e_st[6];
    logic st_w, dacc, ptr_w, dp_w, ind_w;
    @(negedge clk);
    host_req = 1; host_we = we; host_word = word; host_addr = a; host_wdata = wd;
    #8;
    if (!we) chk(req, host_rdata, exp_rd(a, word));
    st_w  = hi & we & ~word & ((lo & 8'hF0) == 8'h80);
    dp_w  = hi & we & ~word & ((lo & 8'hF1) == 8'hE1);
    ptr_w = hi & we & ~word & (lo == 8'hC1);
    ind_w = hi & we & ~word & (lo == 8'hC3);
    dacc  = hi & ((~we & ~word & ((lo & 8'hF1) == 8'h81)) | dp_w |
                  (~we & word & ((lo & 8'hF0) == 8'h80)) |
                  (~word & lo == 8'hC3 & m_ptr == DATA_REG));
    @(posedge clk); #2;
    if (st_w) e_st = wd[6:0];
    else if (dacc && dav && e_st[4]) e_st[3] = 1'b1;
    if (in_rst) m_ptr = 0;
    else begin
      if (ptr_w) m_ptr = wd[7:0];
      if (dp_w) m_regs[DATA_REG[4:0]] = wd[7:0];
      if (ind_w) m_regs[m_ptr[4:0]] = wd[7:0];
    end
    chk("R8 R9 irq", {15'h0, irq}, {15'h0, e_st[3]});
    chk("R5 ctl_reset", {15'h0, ctl_reset}, {15'h0, ~e_st[6]});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) m_regs[i] = 8'(i * 13);
    repeat (3) @(posedge clk);
    #2;
    chk("R5 reset ctl_reset", {15'h0, ctl_reset}, 16'h1);
    chk("R5 reset irq", {15'h0, irq}, 16'h0);
    @(negedge clk) rst = 0;
    op(0, 0, 16'h8080, 0, "R3 status after reset");
    op(1, 0, 16'h8080, 16'h0050, "R4 write status");          // run + int enable
    op(0, 0, 16'h8090, 0, "R3 status alias");
    op(0, 0, 16'h0010, 0, "R1 rom byte");
    op(0, 1, 16'h0010, 0, "R1 rom word");
    op(0, 1, 16'h3FFF, 0, "R2 rom word crossing limit");
    op(0, 0, 16'h4000, 0, "R2 rom beyond limit");
    op(0, 1, 16'h7FFF, 0, "R2 rom top of slot");
    op(1, 0, 16'h0080, 16'h0000, "R2 rom write ignored");
    op(0, 0, 16'h8080, 0, "R2 status after rom write");
    op(1, 0, 16'h80C1, 16'h0005, "R7 pointer write");
    op(1, 0, 16'h80C3, 16'h00A7, "R7 indirect write");
    op(0, 0, 16'h80C3, 0, "R7 indirect read");
    op(1, 0, 16'h80E1, 16'h003C, "R6 data port write");
    op(0, 0, 16'h8081, 0, "R6 data port read");
    op(0, 0, 16'h80C3, 0, "R6 pointer kept");
    dav = 1;
    op(0, 0, 16'h80C1, 0, "R7 aux read");
    op(0, 0, 16'h8080, 0, "R3 status dav bit");
    op(0, 0, 16'h80C3, 0, "R8 no event off data reg");
    op(0, 0, 16'h8081, 0, "R8 data read raises irq");
    op(0, 0, 16'h8080, 0, "R9 irq pending visible");
    dav = 0;
    op(0, 0, 16'h8081, 0, "R9 irq holds");
    op(1, 1, 16'h8080, 16'h0000, "R10 word write ignored");
    op(0, 1, 16'h8082, 0, "R10 word status+data");
    op(0, 0, 16'h80A5, 0, "R11 unmapped byte");
    op(0, 1, 16'h80C0, 0, "R11 unmapped word");
    op(1, 0, 16'h8080, 16'h0050, "R9 clear pending");
    op(1, 0, 16'h80C1, 16'h0019, "R8 pointer to data reg");
    dav = 1;
    op(1, 0, 16'h80C3, 16'h0011, "R8 indirect data event");
    op(1, 0, 16'h8080, 16'h0010, "R5 clear run bit");
    op(0, 0, 16'h80C3, 0, "R5 pointer zero in reset");
    op(1, 0, 16'h8080, 16'h0040, "R5 release reset");
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] a, wd;
      logic we, word;
      int k = $urandom % 12;
      dav = $urandom % 2;
      we = $urandom % 2;
      word = ($urandom % 4) == 0;
      wd = 16'($urandom);
      case (k)
        0: a = 16'h8080 | 16'(($urandom % 2) << 4);
        1: a = 16'h8081 | 16'(($urandom % 8) << 1);
        2: a = 16'h80E1;
        3: begin a = 16'h80C1; wd = ($urandom % 2) ? 16'h0019 : 16'($urandom % 32); end
        4, 5: a = 16'h80C3;
        6: a = 16'h8000 | 16'($urandom % 256);
        7, 8: a = 16'($urandom % 32768);
        default: a = 16'h8081;
      endcase
      if (k == 0 && we && !word) wd[6] = ($urandom % 10) != 0;
      op(we, word, a, wd, "R1 R3 R4 R6 R7 R10 R11 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule